// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This block sits between a 32-bit integer datapath and a data memory that is one word wide. Addresses are byte addresses, and lanes are laid out big-endian: within a word, the byte at offset 0 is the most significant byte. The effective address reaches the unit already formed. Upstream logic sign-extends a 16-bit displacement and adds it to a base register, and the unit has no other addressing mode.

For a store, the unit turns the effective address, the store data and a size code into three things: a word-aligned memory address, write data copied across the lanes, and one write enable per byte lane. For a load, it sends the aligned address and a read strobe. One cycle later it takes the returned word, picks out the addressed byte or halfword, and sign- or zero-extends it to a full 32-bit result. When an access does not sit on a multiple of its own size, the unit raises an address error and the access has no effect on memory.

Top module: `lsu_lane_unit`

## Requirements
- R1: `mem_addr` equals `req_addr` with its two low bits cleared.
- R2: For a byte store (`req_size`=2'b00), the data byte `req_wdata[7:0]` is copied into all four lanes of `mem_wdata`. Exactly one enable is set: offset 0 enables `mem_we[3]` (bits 31:24) and offset 3 enables `mem_we[0]` (bits 7:0).
- R3: For a halfword store (`req_size`=2'b01), `req_wdata[15:0]` is copied into both halves of `mem_wdata`. Offset 0 gives `mem_we`=4'b1100 and offset 2 gives 4'b0011.
- R4: For a word store (`req_size`=2'b10) at offset 0, `mem_wdata` equals `req_wdata` and `mem_we`=4'b1111.
- R5: While `req_valid` is high, `addr_err` is set in the same cycle in three cases: a halfword at an odd address, a word whose two low address bits are not 00, or the reserved size code 2'b11. A byte access never sets it.
- R6: An access that raises `addr_err` drives `mem_we` to 4'b0000 and `mem_re` to 0, and produces no `ld_valid` in the next cycle.
- R7: A signed byte load (`req_unsigned`=0) returns the addressed byte sign-extended to 32 bits. Offset 0 selects `mem_rdata[31:24]`.
- R8: Unsigned byte and halfword loads (`req_unsigned`=1) zero-extend the selected data to 32 bits.
- R9: A signed halfword load returns the addressed halfword sign-extended. Offset 0 selects `mem_rdata[31:16]` and offset 2 selects bits 15:0.
- R10: A word load returns the whole of `mem_rdata`.
- R11: An aligned load drives `mem_re` high in its request cycle. In the following cycle, `ld_valid` is high and `ld_data` is formed from the `mem_rdata` present in that cycle. Loads may be issued on back-to-back cycles.
- R12: While `req_valid` is low, `addr_err`, `mem_re` and every bit of `mem_we` stay 0, whatever the address and size.
- R13: During and immediately after reset, `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | Zero-extend a load result instead of sign-extending |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store data, right-justified |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_we | output | 4 | Per-lane write enables; bit 3 is bits 31:24 |
| mem_re | output | 1 | Read strobe for an aligned load |
| mem_rdata | input | 32 | Word returned by memory one cycle after `mem_re` |
| addr_err | output | 1 | Misaligned or reserved-size access |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- **Lane order at both ends of the word.** Offset 0 and offset 3 are both tested. A little-endian lane map would swap their enables and return the wrong byte.
- **Sign bit set versus clear.** Loads use the bytes 0x80 and 0x7E. A design that extends from the wrong bit, or that ignores the unsigned flag, would yield ones where zeros belong, or the reverse.
- **Misaligned and reserved-size requests.** These are checked for both stores and loads. A design that only flags the error, without cancelling the access, would still write lanes, still strobe the read, or still produce a load result.
- **Back-to-back loads.** These catch a result register that holds control fields for the wrong cycle.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;
endpackage

// File: rtl/lsu_align_check.sv
`timescale 1ns/1ps
module lsu_align_check
   import lsu_pkg::*;
#(
   parameter int OFF_W = 2
) (
   input  acc_size_e          size,
   input  logic [OFF_W-1:0]   off,
   output logic               misal
);
   always_comb begin
      unique case (size)
         SZ_BYTE: misal = 1'b0;
         SZ_HALF: misal = off[0];
         SZ_WORD: misal = |off;
         default: misal = 1'b1;
      endcase
   end
endmodule

// File: rtl/lsu_store_lanes.sv
`timescale 1ns/1ps
module lsu_store_lanes
   import lsu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8,
   parameter int OFF_W  = $clog2(LANES)
) (
   input  logic                enable,
   input  acc_size_e           size,
   input  logic [OFF_W-1:0]    off,
   input  logic [DATA_W-1:0]   wdata_in,
   output logic [LANES-1:0]    we,
   output logic [DATA_W-1:0]   wdata_out
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      // byte offset held by lane k under big-endian ordering
      localparam logic [OFF_W-1:0] BPOS = OFF_W'(LANES - 1 - k);
      logic hit;
      always_comb begin
         unique case (size)
            SZ_BYTE: hit = (off == BPOS);
            SZ_HALF: hit = (off[OFF_W-1:1] == BPOS[OFF_W-1:1]);
            SZ_WORD: hit = 1'b1;
            default: hit = 1'b0;
         endcase
      end
      assign we[k] = enable & hit;

      always_comb begin
         unique case (size)
            SZ_BYTE: wdata_out[k*8 +: 8] = wdata_in[7:0];
            SZ_HALF: wdata_out[k*8 +: 8] = wdata_in[(k % 2)*8 +: 8];
            default: wdata_out[k*8 +: 8] = wdata_in[k*8 +: 8];
         endcase
      end
   end
endmodule

// File: rtl/lsu_load_extract.sv
`timescale 1ns/1ps
module lsu_load_extract
   import lsu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8,
   parameter int OFF_W  = $clog2(LANES)
) (
   input  acc_size_e           size,
   input  logic                uns,
   input  logic [OFF_W-1:0]    off,
   input  logic [DATA_W-1:0]   rdata,
   output logic [DATA_W-1:0]   result
);
   localparam int HALVES = LANES / 2;

   logic [7:0]  by_off [LANES];
   logic [15:0] hw_off [HALVES];

   for (genvar o = 0; o < LANES; o++) begin : g_byte
      assign by_off[o] = rdata[(LANES - 1 - o)*8 +: 8];
   end
   for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign hw_off[h] = rdata[(HALVES - 1 - h)*16 +: 16];
   end

   logic [7:0]  sel_b;
   logic [15:0] sel_h;
   assign sel_b = by_off[off];
   assign sel_h = hw_off[off[OFF_W-1:1]];

   always_comb begin
      unique case (size)
         SZ_BYTE: result = {{(DATA_W-8){~uns & sel_b[7]}}, sel_b};
         SZ_HALF: result = {{(DATA_W-16){~uns & sel_h[15]}}, sel_h};
         default: result = rdata;
      endcase
   end
endmodule

// File: rtl/lsu_lane_unit.sv
`timescale 1ns/1ps
module lsu_lane_unit
   import lsu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_store,
   input  logic [1:0]               req_size,
   input  logic                     req_unsigned,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [DATA_W-1:0]        mem_wdata,
   output logic [DATA_W/8-1:0]      mem_we,
   output logic                     mem_re,
   input  logic [DATA_W-1:0]        mem_rdata,
   output logic                     addr_err,
   output logic                     ld_valid,
   output logic [DATA_W-1:0]        ld_data
);
   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || LANES < 4 || (1 << OFF_W) != LANES) begin : g_bad_width
      $error("lsu_lane_unit: DATA_W must be a power-of-two number of bytes, at least 4");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("lsu_lane_unit: ADDR_W too small for the lane offset");
   end

   acc_size_e           size;
   logic [OFF_W-1:0]    off;
   logic                misal;
   logic                st_go;

   assign size     = acc_size_e'(req_size);
   assign off      = req_addr[OFF_W-1:0];
   assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign addr_err = req_valid & misal;
   assign st_go    = req_valid & req_store & ~misal;
   assign mem_re   = req_valid & ~req_store & ~misal;

   lsu_align_check #(.OFF_W(OFF_W)) u_align (
      .size  (size),
      .off   (off),
      .misal (misal)
   );

   lsu_store_lanes #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_store (
      .enable    (st_go),
      .size      (size),
      .off       (off),
      .wdata_in  (req_wdata),
      .we        (mem_we),
      .wdata_out (mem_wdata)
   );

   // load control carried across the memory read cycle
   logic                ld_valid_q;
   acc_size_e           ld_size_q;
   logic                ld_uns_q;
   logic [OFF_W-1:0]    ld_off_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_valid_q <= 1'b0;
         ld_size_q  <= SZ_WORD;
         ld_uns_q   <= 1'b0;
         ld_off_q   <= '0;
      end else begin
         ld_valid_q <= mem_re;
         if (mem_re) begin
            ld_size_q <= size;
            ld_uns_q  <= req_unsigned;
            ld_off_q  <= off;
         end
      end
   end

   logic [DATA_W-1:0] ext_data;

   lsu_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_load (
      .size   (ld_size_q),
      .uns    (ld_uns_q),
      .off    (ld_off_q),
      .rdata  (mem_rdata),
      .result (ext_data)
   );

   assign ld_valid = ld_valid_q;
   assign ld_data  = ld_valid_q ? ext_data : '0;

   // ---------------- assertions ----------------
   a_r6_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> (mem_we == '0 && !mem_re));

   a_r6_err_no_result: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store && addr_err) |=> !ld_valid);

   a_r11_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store && !addr_err) |=> ld_valid);

   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!addr_err && !mem_re && mem_we == '0));

   a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && size == SZ_BYTE) |-> $countones(mem_we) == 1);

   a_r3_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && size == SZ_HALF && !addr_err) |-> $countones(mem_we) == 2);

   a_r5_byte_never_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && size == SZ_BYTE) |-> !addr_err);

   a_r8_zero_ext_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_uns_q && ld_size_q == SZ_BYTE) |-> ld_data[DATA_W-1:8] == '0);
endmodule

// File: tb/tb_lsu_lane_unit.sv
`timescale 1ns/1ps
module tb_lsu_lane_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic        req_unsigned = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [3:0]  mem_we;
   logic        mem_re;
   logic [31:0] mem_rdata = '0;
   logic        addr_err;
   logic        ld_valid;
   logic [31:0] ld_data;

   always #5 clk = ~clk;

   lsu_lane_unit dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
      .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
      .addr_err(addr_err), .ld_valid(ld_valid), .ld_data(ld_data)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic        st;
      logic [1:0]  sz;
      logic        un;
      logic [1:0]  off;
      logic [31:0] data;
      logic [3:0]  we;
      logic        err;
      logic [31:0] exp;
   } vec_t;

   localparam logic [31:0] BASE = 32'h0040_1230;
   localparam logic [31:0] SD   = 32'h1234_56A7;
   localparam logic [31:0] MW   = 32'h80F1_7E22;
   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2'd0, 1'b0, 2'd0, SD, 4'b1000, 1'b0, 32'hA7A7_A7A7},
      '{1'b1, 2'd0, 1'b0, 2'd3, SD, 4'b0001, 1'b0, 32'hA7A7_A7A7},
      '{1'b1, 2'd1, 1'b0, 2'd0, SD, 4'b1100, 1'b0, 32'h56A7_56A7},
      '{1'b1, 2'd1, 1'b0, 2'd2, SD, 4'b0011, 1'b0, 32'h56A7_56A7},
      '{1'b1, 2'd2, 1'b0, 2'd0, SD, 4'b1111, 1'b0, 32'h1234_56A7},
      '{1'b1, 2'd1, 1'b0, 2'd1, SD, 4'b0000, 1'b1, 32'h0},
      '{1'b1, 2'd2, 1'b0, 2'd2, SD, 4'b0000, 1'b1, 32'h0},
      '{1'b1, 2'd3, 1'b0, 2'd0, SD, 4'b0000, 1'b1, 32'h0},
      '{1'b0, 2'd0, 1'b0, 2'd0, MW, 4'b0000, 1'b0, 32'hFFFF_FF80},
      '{1'b0, 2'd0, 1'b0, 2'd1, MW, 4'b0000, 1'b0, 32'hFFFF_FFF1},
      '{1'b0, 2'd0, 1'b0, 2'd2, MW, 4'b0000, 1'b0, 32'h0000_007E},
      '{1'b0, 2'd0, 1'b1, 2'd0, MW, 4'b0000, 1'b0, 32'h0000_0080},
      '{1'b0, 2'd0, 1'b1, 2'd3, MW, 4'b0000, 1'b0, 32'h0000_0022},
      '{1'b0, 2'd1, 1'b0, 2'd0, MW, 4'b0000, 1'b0, 32'hFFFF_80F1},
      '{1'b0, 2'd1, 1'b0, 2'd2, MW, 4'b0000, 1'b0, 32'h0000_7E22},
      '{1'b0, 2'd1, 1'b1, 2'd0, MW, 4'b0000, 1'b0, 32'h0000_80F1},
      '{1'b0, 2'd2, 1'b0, 2'd0, MW, 4'b0000, 1'b0, 32'h80F1_7E22},
      '{1'b0, 2'd2, 1'b0, 2'd1, MW, 4'b0000, 1'b1, 32'h0},
      '{1'b0, 2'd1, 1'b0, 2'd3, MW, 4'b0000, 1'b1, 32'h0}
   };

   function automatic string tag_of(input vec_t v);
      if (v.err) return "R6";
      if (v.st) return (v.sz == 2'd0) ? "R2" : (v.sz == 2'd1) ? "R3" : "R4";
      if (v.sz == 2'd2) return "R10";
      if (v.un) return "R8";
      return (v.sz == 2'd0) ? "R7" : "R9";
   endfunction

   initial begin
      // R13: reset state
      repeat (3) @(negedge clk);
      chk("R13 ld_valid in reset", {31'd0, ld_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13 ld_valid after reset", {31'd0, ld_valid}, 32'd0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         string t;
         v = VECS[i];
         t = tag_of(v);
         @(negedge clk);
         req_valid    = 1'b1;
         req_store    = v.st;
         req_size     = v.sz;
         req_unsigned = v.un;
         req_addr     = {BASE[31:2], v.off};
         req_wdata    = v.st ? v.data : 32'hDEAD_BEEF;
         mem_rdata    = 32'h0;
         #2;
         chk("R1 mem_addr", mem_addr, {BASE[31:2], 2'b00});
         chk("R5 addr_err", {31'd0, addr_err}, {31'd0, v.err});
         if (v.st) begin
            chk({t, " mem_we"}, {28'd0, mem_we}, {28'd0, v.we});
            if (!v.err) chk({t, " mem_wdata"}, mem_wdata, v.exp);
         end else begin
            chk({t, " mem_re"}, {31'd0, mem_re}, {31'd0, ~v.err});
            chk({t, " mem_we on load"}, {28'd0, mem_we}, 32'd0);
         end
         @(negedge clk);
         req_valid = 1'b0;
         mem_rdata = v.data;
         #2;
         if (!v.st) begin
            chk({t, " R11 ld_valid"}, {31'd0, ld_valid}, {31'd0, ~v.err});
            if (!v.err) chk({t, " ld_data"}, ld_data, v.exp);
         end
      end

      // R12: idle with a misaligned word address and store asserted
      @(negedge clk);
      req_valid = 1'b0; req_store = 1'b1; req_size = 2'd2; req_addr = BASE | 32'd1;
      #2;
      chk("R12 addr_err idle", {31'd0, addr_err}, 32'd0);
      chk("R12 mem_we idle", {28'd0, mem_we}, 32'd0);
      chk("R12 mem_re idle", {31'd0, mem_re}, 32'd0);

      // R11: back-to-back loads, signed byte at offset 1 then unsigned half at offset 2
      @(negedge clk);
      req_valid = 1'b1; req_store = 1'b0; req_size = 2'd0; req_unsigned = 1'b0;
      req_addr = {BASE[31:2], 2'd1}; mem_rdata = 32'h0;
      @(negedge clk);
      req_size = 2'd1; req_unsigned = 1'b1; req_addr = {BASE[31:2], 2'd2};
      mem_rdata = 32'h0C85_F3B4;
      #2;
      chk("R11 first of pair valid", {31'd0, ld_valid}, 32'd1);
      chk("R11 first of pair data", ld_data, 32'hFFFF_FF85);
      @(negedge clk);
      req_valid = 1'b0;
      mem_rdata = 32'h1111_9ABC;
      #2;
      chk("R11 second of pair valid", {31'd0, ld_valid}, 32'd1);
      chk("R8 second of pair data", ld_data, 32'h0000_9ABC);
      @(negedge clk);
      #2;
      chk("R11 no result without request", {31'd0, ld_valid}, 32'd0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule